// File: doc/BRIEF.md
# Zero-Bit-Scan Control Escalation Detector

This block sits beside a chip-level JTAG TAP controller on the target side. It watches the controller state on every TCK edge and looks for DR scans that go from Select-DR-Scan to Update-DR without ever reaching Shift-DR. These are zero-bit scans. It counts them, and it freezes the count when the first DR scan that does shift arrives. A frozen count of two or more raises an extended control level equal to that count. An IR scan anywhere since the last Test-Logic-Reset blocks any escalation.

At control level 2 the block decodes a command without using any data pin. Each of the next two DR scans is one 5-bit part, and the value of a part is the number of TCK ticks the controller spends in Shift-DR during that scan. The two parts are joined into a 10-bit code. A one-cycle strobe reports the code as the controller enters Update-DR at the end of the second part. A part longer than 31 ticks raises an error flag, and the strobe is then withheld.

Top module: `zbs_escalator`

## Requirements
- R1: While rst_n is low, ctrl_level, cmd_valid, cmd_code and cmd_err are all zero.
- R2: A DR scan that reaches Update-DR through Exit1-DR, or through Pause-DR and Exit2-DR, without visiting Shift-DR adds one to the zero-bit-scan count.
- R3: The first DR scan that visits Shift-DR locks the count. If the count is 2 or more, ctrl_level takes that value from the cycle in which the controller is in Update-DR of that scan, and it holds that value until the level is exited.
- R4: If fewer than two zero-bit scans came before the locking scan, ctrl_level stays 0 and no command is decoded until the next Test-Logic-Reset.
- R5: Once an IR scan has begun (Select-IR-Scan reached) after Test-Logic-Reset, later zero-bit scans and locking scans leave ctrl_level at 0 until Test-Logic-Reset is visited again.
- R6: Reaching Select-IR-Scan or Test-Logic-Reset drops ctrl_level to 0 on the next TCK edge.
- R7: Test-Logic-Reset clears the zero-bit-scan count, so that the scans counted before it do not count toward the next lock.
- R8: The value of a command part is the total number of TCK cycles spent in Shift-DR during that one DR scan, added up across any Pause-DR excursions. A scan with no Shift-DR gives 0.
- R9: At level 2 the two DR scans after the locking scan form the command. cmd_code is {first part, second part}, with the first part in bits [9:5]. cmd_valid is high for exactly one cycle, the cycle in which the controller is in Update-DR of the second part.
- R10: After the strobe, further DR scans at the same level produce no more strobes.
- R11: A part longer than 31 ticks saturates at 31 and sets cmd_err, and no strobe is given for that command. cmd_err stays set until the level is exited.
- R12: At levels above 2, no command is decoded and cmd_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Test mode select, sampled with tap_state to detect the entry into Update-DR |
| tap_state | input | 4 | Current TAP state: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR |
| ctrl_level | output | 4 | Locked extended control level, 0 when none is active |
| cmd_valid | output | 1 | One-cycle strobe when a command code is complete |
| cmd_code | output | 10 | Last completed command code |
| cmd_err | output | 1 | A command part exceeded 31 ticks |

## Verification
The hardest case to reach is a second command part that hits the 31-tick limit, or a part whose Shift-DR time is split by a Pause-DR excursion. To get there, the controller must first pass through reset, an exact number of zero-bit scans on both routes, and a locking scan, with no IR scan at any point. The bench drives TMS into its own model of the TAP state machine and feeds the resulting state to the block. Scan helpers produce scans with exact tick counts, and each row of a table runs one complete reset-escalate-command sequence. Directed sequences then cover IR disqualification, exit through Select-IR-Scan, the clearing of the count by reset, and the split-shift case.

// File: rtl/zbs_pkg.sv
package zbs_pkg;

    localparam int PART_W    = 5;
    localparam int NUM_PARTS = 2;
    localparam int LVL_W     = 4;
    localparam int CMD_LEVEL = 2;

    typedef enum logic [3:0] {
        TAP_RESET    = 4'd0,
        TAP_IDLE     = 4'd1,
        TAP_SEL_DR   = 4'd2,
        TAP_CAP_DR   = 4'd3,
        TAP_SHIFT_DR = 4'd4,
        TAP_EX1_DR   = 4'd5,
        TAP_PAUSE_DR = 4'd6,
        TAP_EX2_DR   = 4'd7,
        TAP_UPD_DR   = 4'd8,
        TAP_SEL_IR   = 4'd9,
        TAP_CAP_IR   = 4'd10,
        TAP_SHIFT_IR = 4'd11,
        TAP_EX1_IR   = 4'd12,
        TAP_PAUSE_IR = 4'd13,
        TAP_EX2_IR   = 4'd14,
        TAP_UPD_IR   = 4'd15
    } tap_state_t;

endpackage

// File: rtl/zbs_scan_meter.sv
// Measures one DR scan: whether Shift-DR was visited and how many ticks it held.
module zbs_scan_meter
    import zbs_pkg::*;
#(
    parameter int TICK_W = PART_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tap_state_t        st,
    input  logic              tms,
    output logic              scan_end,
    output logic              scan_shifted,
    output logic [TICK_W-1:0] scan_ticks,
    output logic              scan_ovf
);

    localparam logic [TICK_W-1:0] TICK_MAX = '1;

    typedef struct packed {
        logic              shifted;
        logic [TICK_W-1:0] ticks;
        logic              ovf;
    } meter_t;

    meter_t meter_d, meter_q;

    always_comb begin
        meter_d = meter_q;
        if (st == TAP_SEL_DR) begin
            meter_d = '0;
        end else if (st == TAP_SHIFT_DR) begin
            meter_d.shifted = 1'b1;
            if (meter_q.ticks == TICK_MAX) begin
                meter_d.ovf = 1'b1;
            end else begin
                meter_d.ticks = meter_q.ticks + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) meter_q <= '0;
        else        meter_q <= meter_d;
    end

    // The edge that moves the controller into Update-DR ends the scan.
    assign scan_end     = ((st == TAP_EX1_DR) || (st == TAP_EX2_DR)) && tms;
    assign scan_shifted = meter_q.shifted;
    assign scan_ticks   = meter_q.ticks;
    assign scan_ovf     = meter_q.ovf;

    p_tick_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TAP_SHIFT_DR && meter_q.ticks == TICK_MAX)
        |=> (meter_q.ovf && meter_q.ticks == TICK_MAX));

    p_scan_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TAP_SEL_DR) |=> (meter_q.ticks == '0 && !meter_q.shifted));

endmodule

// File: rtl/zbs_level_ctl.sv
// Counts zero-bit scans, locks the count and holds the extended control level.
module zbs_level_ctl
    import zbs_pkg::*;
#(
    parameter int LEVEL_W = LVL_W,
    parameter int ESC_MIN = CMD_LEVEL
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tap_state_t         st,
    input  logic               scan_end,
    input  logic               scan_shifted,
    output logic [LEVEL_W-1:0] level,
    output logic               level_exit
);

    localparam logic [LEVEL_W-1:0] ZCNT_MAX  = '1;
    localparam logic [LEVEL_W-1:0] ESC_MIN_V = LEVEL_W'(ESC_MIN);

    typedef struct packed {
        logic [LEVEL_W-1:0] zcnt;
        logic               locked;
        logic               ir_seen;
        logic [LEVEL_W-1:0] level;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (st == TAP_RESET) begin
            ctl_d = '0;
        end else if (st == TAP_SEL_IR) begin
            ctl_d.ir_seen = 1'b1;
            ctl_d.locked  = 1'b0;
            ctl_d.level   = '0;
            ctl_d.zcnt    = '0;
        end else if (scan_end && !ctl_q.locked && !ctl_q.ir_seen) begin
            if (!scan_shifted) begin
                if (ctl_q.zcnt != ZCNT_MAX) ctl_d.zcnt = ctl_q.zcnt + 1'b1;
            end else begin
                ctl_d.locked = 1'b1;
                ctl_d.level  = (ctl_q.zcnt >= ESC_MIN_V) ? ctl_q.zcnt : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign level      = ctl_q.level;
    assign level_exit = (st == TAP_RESET) || (st == TAP_SEL_IR);

    p_reset_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TAP_RESET) |=> (ctl_q.zcnt == '0 && ctl_q.level == '0));

    p_ir_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TAP_SEL_IR) |=> (ctl_q.level == '0 && !ctl_q.locked));

    p_ir_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ir_seen && st != TAP_RESET) |=> (ctl_q.level == '0));

    p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.locked && !level_exit) |=> $stable(ctl_q.level));

    p_low_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_end && scan_shifted && !ctl_q.locked && ctl_q.zcnt < ESC_MIN_V)
        |=> (ctl_q.level == '0));

endmodule

// File: rtl/zbs_cmd_collect.sv
// Collects the command parts at the command level and strobes the joined code.
module zbs_cmd_collect
    import zbs_pkg::*;
#(
    parameter int TICK_W  = PART_W,
    parameter int NPARTS  = NUM_PARTS,
    parameter int LEVEL_W = LVL_W,
    parameter int CMD_LVL = CMD_LEVEL
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LEVEL_W-1:0]       level,
    input  logic                     level_exit,
    input  logic                     scan_end,
    input  logic [TICK_W-1:0]        scan_ticks,
    input  logic                     scan_ovf,
    output logic                     cmd_valid,
    output logic [TICK_W*NPARTS-1:0] cmd_code,
    output logic                     cmd_err
);

    localparam int                 CODE_W    = TICK_W * NPARTS;
    localparam int                 IDX_W     = $clog2(NPARTS + 1);
    localparam logic [IDX_W-1:0]   LAST_IDX  = IDX_W'(NPARTS - 1);
    localparam logic [LEVEL_W-1:0] CMD_LVL_V = LEVEL_W'(CMD_LVL);

    typedef struct packed {
        logic [IDX_W-1:0]               idx;
        logic [NPARTS-1:0][TICK_W-1:0]  parts;
        logic [CODE_W-1:0]              code;
        logic                           valid;
        logic                           err;
    } col_t;

    col_t col_d, col_q;
    logic [CODE_W-1:0] joined;

    always_comb begin
        col_d       = col_q;
        col_d.valid = 1'b0;
        if (level_exit) begin
            col_d.idx = '0;
            col_d.err = 1'b0;
        end else if (scan_end && level == CMD_LVL_V && col_q.idx <= LAST_IDX) begin
            col_d.parts[col_q.idx] = scan_ticks;
            col_d.err              = col_q.err | scan_ovf;
            col_d.idx              = col_q.idx + 1'b1;
            if (col_q.idx == LAST_IDX && !(col_q.err | scan_ovf)) begin
                col_d.valid = 1'b1;
                col_d.code  = joined;
            end
        end
    end

    // First part lands in the most significant field.
    always_comb begin
        joined = '0;
        for (int i = 0; i < NPARTS; i++) begin
            joined[CODE_W-1-i*TICK_W -: TICK_W] = col_d.parts[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign cmd_valid = col_q.valid;
    assign cmd_code  = col_q.code;
    assign cmd_err   = col_q.err;

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        col_q.valid |=> !col_q.valid);

    p_valid_only_cmd_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        col_q.valid |-> (level == CMD_LVL_V));

    p_err_blocks_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        col_q.err |-> !col_q.valid);

    p_exit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        level_exit |=> (col_q.idx == '0 && !col_q.err));

endmodule

// File: rtl/zbs_escalator.sv
module zbs_escalator
    import zbs_pkg::*;
#(
    parameter int TICK_W  = PART_W,
    parameter int NPARTS  = NUM_PARTS,
    parameter int LEVEL_W = LVL_W,
    parameter int CMD_LVL = CMD_LEVEL
) (
    input  logic                     tck,
    input  logic                     rst_n,
    input  logic                     tms,
    input  logic [3:0]               tap_state,
    output logic [LEVEL_W-1:0]       ctrl_level,
    output logic                     cmd_valid,
    output logic [TICK_W*NPARTS-1:0] cmd_code,
    output logic                     cmd_err
);

    tap_state_t        st;
    logic              scan_end;
    logic              scan_shifted;
    logic [TICK_W-1:0] scan_ticks;
    logic              scan_ovf;
    logic              level_exit;

    assign st = tap_state_t'(tap_state);

    zbs_scan_meter #(.TICK_W(TICK_W)) u_meter (
        .clk          (tck),
        .rst_n        (rst_n),
        .st           (st),
        .tms          (tms),
        .scan_end     (scan_end),
        .scan_shifted (scan_shifted),
        .scan_ticks   (scan_ticks),
        .scan_ovf     (scan_ovf)
    );

    zbs_level_ctl #(.LEVEL_W(LEVEL_W), .ESC_MIN(CMD_LVL)) u_level (
        .clk          (tck),
        .rst_n        (rst_n),
        .st           (st),
        .scan_end     (scan_end),
        .scan_shifted (scan_shifted),
        .level        (ctrl_level),
        .level_exit   (level_exit)
    );

    zbs_cmd_collect #(
        .TICK_W  (TICK_W),
        .NPARTS  (NPARTS),
        .LEVEL_W (LEVEL_W),
        .CMD_LVL (CMD_LVL)
    ) u_collect (
        .clk        (tck),
        .rst_n      (rst_n),
        .level      (ctrl_level),
        .level_exit (level_exit),
        .scan_end   (scan_end),
        .scan_ticks (scan_ticks),
        .scan_ovf   (scan_ovf),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_err    (cmd_err)
    );

endmodule

// File: tb/sim_zbs_escalator.sv
module sim_zbs_escalator;
    import zbs_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tms = 1'b1;
    tap_state_t cur = TAP_RESET;
    logic [3:0] ctrl_level;
    logic       cmd_valid;
    logic [9:0] cmd_code;
    logic       cmd_err;

    int errs = 0;
    int checks = 0;
    bit finished = 0;
    int nz, p1, p2, lvl, expv;

    always #5 clk = ~clk;

    zbs_escalator u0 (
        .tck        (clk),
        .rst_n      (rst_n),
        .tms        (tms),
        .tap_state  (cur),
        .ctrl_level (ctrl_level),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_err    (cmd_err)
    );

    function automatic tap_state_t nxt(tap_state_t s, logic t);
        case (s)
            TAP_RESET:    return t ? TAP_RESET    : TAP_IDLE;
            TAP_IDLE:     return t ? TAP_SEL_DR   : TAP_IDLE;
            TAP_SEL_DR:   return t ? TAP_SEL_IR   : TAP_CAP_DR;
            TAP_CAP_DR:   return t ? TAP_EX1_DR   : TAP_SHIFT_DR;
            TAP_SHIFT_DR: return t ? TAP_EX1_DR   : TAP_SHIFT_DR;
            TAP_EX1_DR:   return t ? TAP_UPD_DR   : TAP_PAUSE_DR;
            TAP_PAUSE_DR: return t ? TAP_EX2_DR   : TAP_PAUSE_DR;
            TAP_EX2_DR:   return t ? TAP_UPD_DR   : TAP_SHIFT_DR;
            TAP_UPD_DR:   return t ? TAP_SEL_DR   : TAP_IDLE;
            TAP_SEL_IR:   return t ? TAP_RESET    : TAP_CAP_IR;
            TAP_CAP_IR:   return t ? TAP_EX1_IR   : TAP_SHIFT_IR;
            TAP_SHIFT_IR: return t ? TAP_EX1_IR   : TAP_SHIFT_IR;
            TAP_EX1_IR:   return t ? TAP_UPD_IR   : TAP_PAUSE_IR;
            TAP_PAUSE_IR: return t ? TAP_EX2_IR   : TAP_PAUSE_IR;
            TAP_EX2_IR:   return t ? TAP_UPD_IR   : TAP_SHIFT_IR;
            default:      return t ? TAP_SEL_DR   : TAP_IDLE;
        endcase
    endfunction

    always_ff @(posedge clk) cur <= nxt(cur, tms);

    // Rows: {zero-bit scans, part1 ticks, part2 ticks, expected level}
    localparam logic [19:0] ROWS [8] = '{
        {4'd2, 6'd5,  6'd9,  4'd2},
        {4'd2, 6'd31, 6'd0,  4'd2},
        {4'd2, 6'd0,  6'd31, 4'd2},
        {4'd2, 6'd32, 6'd1,  4'd2},
        {4'd3, 6'd4,  6'd4,  4'd3},
        {4'd1, 6'd6,  6'd2,  4'd0},
        {4'd0, 6'd3,  6'd3,  4'd0},
        {4'd2, 6'd1,  6'd1,  4'd2}
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(logic t);
        @(negedge clk);
        tms = t;
        @(posedge clk);
        #1;
    endtask

    task automatic go_reset_idle();
        repeat (5) step(1'b1);
        step(1'b0);
    endtask

    task automatic zbs(bit via_pause);
        step(1'b1); step(1'b0); step(1'b1);
        if (via_pause) begin step(1'b0); step(1'b1); end
        step(1'b1); step(1'b0);
    endtask

    // Ends in Update-DR; n ticks of Shift-DR (n = 0 means no Shift-DR).
    task automatic dr_scan(int n);
        step(1'b1); step(1'b0);
        if (n == 0) begin
            step(1'b1);
        end else begin
            step(1'b0);
            repeat (n - 1) step(1'b0);
            step(1'b1);
        end
        step(1'b1);
    endtask

    task automatic split_scan(int a, int b);
        step(1'b1); step(1'b0); step(1'b0);
        repeat (a - 1) step(1'b0);
        step(1'b1); step(1'b0); step(1'b1); step(1'b0);
        repeat (b - 1) step(1'b0);
        step(1'b1); step(1'b1);
    endtask

    task automatic ir_scan();
        step(1'b1); step(1'b1); step(1'b0); step(1'b1); step(1'b1); step(1'b0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 level", int'(ctrl_level), 0);
        check("R1 valid", int'(cmd_valid), 0);
        check("R1 code", int'(cmd_code), 0);
        check("R1 err", int'(cmd_err), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table: one full escalate-and-command sequence per row (R2 R3 R4 R9 R11 R12)
        for (int i = 0; i < 8; i++) begin
            nz  = int'(ROWS[i][19:16]);
            p1  = int'(ROWS[i][15:10]);
            p2  = int'(ROWS[i][9:4]);
            lvl = int'(ROWS[i][3:0]);
            expv = (lvl == 2 && p1 <= 31 && p2 <= 31) ? 1 : 0;
            go_reset_idle();
            check("R11 err cleared by reset", int'(cmd_err), 0);
            for (int z = 0; z < nz; z++) zbs(z[0]);
            dr_scan(7);
            check("R3/R4 level after lock", int'(ctrl_level), lvl);
            step(1'b0);
            dr_scan(p1);
            check("R9 no strobe on first part", int'(cmd_valid), 0);
            step(1'b0);
            dr_scan(p2);
            check("R9/R11/R12 strobe", int'(cmd_valid), expv);
            if (expv == 1)
                check("R9 code", int'(cmd_code), ((p1 & 31) << 5) | (p2 & 31));
            check("R11 err flag", int'(cmd_err), (lvl == 2 && expv == 0) ? 1 : 0);
            step(1'b0);
            check("R9 strobe one cycle", int'(cmd_valid), 0);
        end

        // R2: two zero-bit scans through Pause-DR only
        go_reset_idle();
        zbs(1'b1); zbs(1'b1);
        dr_scan(2);
        check("R2 pause-route count", int'(ctrl_level), 2);

        // R5: IR scan disqualifies escalation
        go_reset_idle();
        ir_scan();
        zbs(1'b0); zbs(1'b1);
        dr_scan(3);
        check("R5 level after IR scan", int'(ctrl_level), 0);
        step(1'b0);
        dr_scan(4);
        step(1'b0);
        dr_scan(5);
        check("R5 no command", int'(cmd_valid), 0);

        // R6: Select-IR-Scan exits level
        go_reset_idle();
        zbs(1'b0); zbs(1'b0);
        dr_scan(3);
        check("R6 level before exit", int'(ctrl_level), 2);
        step(1'b0);
        step(1'b1);
        step(1'b1);
        step(1'b0);
        check("R6 level after Select-IR", int'(ctrl_level), 0);

        // R7: Test-Logic-Reset clears earlier count
        go_reset_idle();
        zbs(1'b0);
        step(1'b1); step(1'b1); step(1'b1);
        step(1'b0);
        zbs(1'b1);
        dr_scan(3);
        check("R7 count cleared", int'(ctrl_level), 0);

        // R8: ticks added across a Pause-DR excursion
        go_reset_idle();
        zbs(1'b0); zbs(1'b1);
        dr_scan(4);
        step(1'b0);
        split_scan(3, 4);
        step(1'b0);
        dr_scan(2);
        check("R8 split strobe", int'(cmd_valid), 1);
        check("R8 split code", int'(cmd_code), (7 << 5) | 2);

        // R10: later scans at the same level give no strobe
        step(1'b0);
        dr_scan(5);
        check("R10 no strobe third scan", int'(cmd_valid), 0);
        step(1'b0);
        dr_scan(6);
        check("R10 no strobe fourth scan", int'(cmd_valid), 0);
        check("R10 code held", int'(cmd_code), (7 << 5) | 2);
        check("R3 level still held", int'(ctrl_level), 2);

        finished = 1;
        summary();
        $finish;
    end

endmodule